// File: doc/BRIEF.md
# Power Mode Controller

This block keeps the two power-control bits of a telephone line interface and derives the chip's operating mode from them. The two bits sit in a mode register: a "link down" bit and a "chip down" bit. Together they select one of four modes: normal, reset, sleep or full powerdown (deep sleep). The decoded mode controls three outputs: the enable of the isolation link, the enable of the ring-detect output path, and a flag that says whether line-side status may be trusted.

Software reaches the block through a small register port. The mode register and three clock-generator configuration registers can be written and read back there. Requests to enter sleep or deep sleep are checked against the clock configuration before they take effect. A request that fails the check is dropped and leaves a sticky error flag.

Once the block is in sleep or deep sleep, register writes have no effect. The only way out is a low pulse on the external reset pin, which brings back the reset state. While the block is asleep, a master-clock-present input is watched, and a sticky flag records any loss of that clock.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After a synchronous `rst` or after a cycle with `rst_pin_n` low, the block is in reset mode. The mode register reads 0x10, all three clock registers read 0x00, and `sleep_err` and `clk_loss` are 0.
- R2: The mode register is at address 6, with the chip-down bit at bit 3 and the link-down bit at bit 4. `mode_o` = {chip-down, link-down}, which gives 00 normal, 01 reset, 10 sleep and 11 deep sleep.
- R3: `link_en` and `ring_en` are 1 in normal and sleep and 0 in reset and deep sleep. `status_valid` is 1 only in normal.
- R4: A mode write that requests sleep (bit 3 set, bit 4 clear) is accepted only if the link-down bit is already clear and the registers at addresses 7, 8 and 9 are all nonzero. Otherwise the mode is unchanged and `sleep_err` is set.
- R5: A mode write that requests deep sleep (bits 3 and 4 set) is accepted only if register 9 holds 0x00. Otherwise the mode is unchanged and `sleep_err` is set.
- R6: In sleep and deep sleep, every register write is ignored, while reads still return the stored values.
- R7: Sleep and deep sleep are left only by a low `rst_pin_n`, which leads to reset mode. A mode write of 0x00 does not wake the block.
- R8: `clk_loss` is set in the cycle after `mclk_ok` is sampled low in sleep mode. A low `mclk_ok` in any other mode has no effect.
- R9: `sleep_err` and `clk_loss` stay set until `rst` or a low `rst_pin_n`. Later accepted writes and a returning clock do not clear them.
- R10: Reads return stored values at addresses 7 to 9. At address 6 only bits 3 and 4 can read as 1. Every other address reads 0x00, and writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_pin_n | input | 1 | External reset pin, active low, sampled on `clk` |
| mclk_ok | input | 1 | Master clock present |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| mode_o | output | 2 | Current mode {chip-down, link-down} |
| link_en | output | 1 | Isolation link enable |
| ring_en | output | 1 | Ring-detect output path enable |
| status_valid | output | 1 | Line-side status may be trusted |
| sleep_err | output | 1 | Sticky flag: a sleep or deep-sleep request was refused |
| clk_loss | output | 1 | Sticky flag: the master clock was lost during sleep |

## Verification
The mode write is swept over all four bit pairs. Each request starts from both reset and normal mode and is tried against all eight zero/nonzero patterns of the three clock registers. This separates the sleep guard, which needs all three registers nonzero and a cleared link-down bit, from the deep-sleep guard, which looks only at register 9 and does not care about the starting mode. Separate sequences cover the following: writes aimed at a sleeping block, a clock drop during sleep compared with one during normal mode, a pin-driven exit from each locked mode, and whether the sticky flags survive later accepted writes.

// File: rtl/pwr_mode_pkg.sv
`timescale 1ns/1ps
package pwr_mode_pkg;
    localparam int DATA_W       = 8;
    localparam int ADDR_W       = 4;
    localparam int NUM_CLK_REGS = 3;
    localparam int MODE_ADDR    = 6;
    localparam int CLK_BASE     = 7;
    localparam int PDN_BIT      = 3;
    localparam int PDL_BIT      = 4;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'b00,
        PM_RESET  = 2'b01,
        PM_SLEEP  = 2'b10,
        PM_DEEP   = 2'b11
    } pmode_t;

    typedef struct packed {
        logic chip_dn;
        logic link_dn;
    } pbits_t;

    function automatic pmode_t bits_to_mode(pbits_t b);
        return pmode_t'({b.chip_dn, b.link_dn});
    endfunction

    function automatic logic [DATA_W-1:0] bits_to_byte(pbits_t b);
        logic [DATA_W-1:0] v;
        v = '0;
        v[PDN_BIT] = b.chip_dn;
        v[PDL_BIT] = b.link_dn;
        return v;
    endfunction
endpackage

// File: rtl/pwr_mode_regs.sv
`timescale 1ns/1ps
module pwr_mode_regs
    import pwr_mode_pkg::*;
(
    input  logic                                   clk,
    input  logic                                   clr,
    input  logic                                   wr_en,
    input  logic [ADDR_W-1:0]                      addr,
    input  logic [DATA_W-1:0]                      wdata,
    output pbits_t                                 bits,
    output logic [NUM_CLK_REGS-1:0][DATA_W-1:0]    cfg,
    output logic                                   reject
);
    localparam int LAST = NUM_CLK_REGS - 1;

    logic                    locked;
    logic                    mode_wr;
    logic                    accept;
    logic                    cfg_ok;
    logic                    pll_off;
    logic [NUM_CLK_REGS-1:0] cfg_nz;
    pbits_t                  req;

    // The chip-down bit is set in both sleep and deep sleep
    assign locked  = bits.chip_dn;
    assign mode_wr = wr_en && !locked && (addr == ADDR_W'(MODE_ADDR));
    assign req     = '{chip_dn: wdata[PDN_BIT], link_dn: wdata[PDL_BIT]};

    for (genvar g = 0; g < NUM_CLK_REGS; g++) begin : g_cfg
        logic hit;
        assign hit       = wr_en && !locked && (addr == ADDR_W'(CLK_BASE + g));
        assign cfg_nz[g] = |cfg[g];
        always_ff @(posedge clk) begin
            if (clr)      cfg[g] <= '0;
            else if (hit) cfg[g] <= wdata;
        end
    end

    assign cfg_ok  = &cfg_nz;
    assign pll_off = !cfg_nz[LAST];

    always_comb begin
        if (!req.chip_dn)      accept = 1'b1;
        else if (!req.link_dn) accept = !bits.link_dn && cfg_ok;
        else                   accept = pll_off;
    end

    assign reject = mode_wr && !accept;

    always_ff @(posedge clk) begin
        if (clr)                   bits <= '{chip_dn: 1'b0, link_dn: 1'b1};
        else if (mode_wr && accept) bits <= req;
    end
endmodule

// File: rtl/pwr_mode_decode.sv
`timescale 1ns/1ps
module pwr_mode_decode
    import pwr_mode_pkg::*;
(
    input  pbits_t bits,
    output pmode_t mode,
    output logic   link_en,
    output logic   ring_en,
    output logic   status_valid
);
    assign mode = bits_to_mode(bits);

    always_comb begin
        link_en      = 1'b0;
        ring_en      = 1'b0;
        status_valid = 1'b0;
        unique case (mode)
            PM_NORMAL: begin
                link_en      = 1'b1;
                ring_en      = 1'b1;
                status_valid = 1'b1;
            end
            PM_SLEEP: begin
                link_en = 1'b1;
                ring_en = 1'b1;
            end
            PM_RESET, PM_DEEP: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/pwr_mode_flags.sv
`timescale 1ns/1ps
module pwr_mode_flags
    import pwr_mode_pkg::*;
(
    input  logic   clk,
    input  logic   clr,
    input  logic   reject,
    input  pmode_t mode,
    input  logic   mclk_ok,
    output logic   sleep_err,
    output logic   clk_loss
);
    always_ff @(posedge clk) begin
        if (clr) begin
            sleep_err <= 1'b0;
            clk_loss  <= 1'b0;
        end else begin
            if (reject)                         sleep_err <= 1'b1;
            if (mode == PM_SLEEP && !mclk_ok)   clk_loss  <= 1'b1;
        end
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_pin_n,
    input  logic              mclk_ok,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        mode_o,
    output logic              link_en,
    output logic              ring_en,
    output logic              status_valid,
    output logic              sleep_err,
    output logic              clk_loss
);
    logic                                clr;
    logic                                reject;
    pbits_t                              bits;
    pmode_t                              mode;
    logic [NUM_CLK_REGS-1:0][DATA_W-1:0] cfg;

    assign clr = rst || !rst_pin_n;

    pwr_mode_regs i_regs (
        .clk    (clk),
        .clr    (clr),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .bits   (bits),
        .cfg    (cfg),
        .reject (reject)
    );

    pwr_mode_decode i_decode (
        .bits         (bits),
        .mode         (mode),
        .link_en      (link_en),
        .ring_en      (ring_en),
        .status_valid (status_valid)
    );

    pwr_mode_flags i_flags (
        .clk       (clk),
        .clr       (clr),
        .reject    (reject),
        .mode      (mode),
        .mclk_ok   (mclk_ok),
        .sleep_err (sleep_err),
        .clk_loss  (clk_loss)
    );

    assign mode_o = mode;

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(MODE_ADDR)) rdata = bits_to_byte(bits);
        for (int i = 0; i < NUM_CLK_REGS; i++) begin
            if (addr == ADDR_W'(CLK_BASE + i)) rdata = cfg[i];
        end
    end
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       rst_pin_n,
    input logic       mclk_ok,
    input logic [1:0] mode_o,
    input logic       link_en,
    input logic       ring_en,
    input logic       status_valid,
    input logic       sleep_err,
    input logic       clk_loss
);
    assert_rst_state_R1: assert property (@(posedge clk)
        rst |=> (mode_o == 2'b01 && !sleep_err && !clk_loss));

    assert_status_normal_R3: assert property (@(posedge clk) disable iff (rst)
        status_valid |-> (mode_o == 2'b00 && link_en));

    assert_link_off_R3: assert property (@(posedge clk) disable iff (rst)
        mode_o[0] |-> (!link_en && !ring_en));

    assert_sleep_from_normal_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b10 && $past(mode_o) != 2'b10) |-> $past(mode_o) == 2'b00);

    assert_locked_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_o[1] && rst_pin_n) |=> $stable(mode_o));

    assert_pin_exit_R7: assert property (@(posedge clk) disable iff (rst)
        !rst_pin_n |=> mode_o == 2'b01);

    assert_clk_loss_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b10 && !mclk_ok && rst_pin_n) |=> clk_loss);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (sleep_err && rst_pin_n) |=> sleep_err);

    assert_loss_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (clk_loss && rst_pin_n) |=> clk_loss);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk i_chk (.*);

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rst_pin_n = 1'b1;
    logic       mclk_ok = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [1:0] mode_o;
    logic       link_en, ring_en, status_valid, sleep_err, clk_loss;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwr_mode_ctrl i_pwr_mode_ctrl (
        .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .mclk_ok(mclk_ok),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .mode_o(mode_o), .link_en(link_en), .ring_en(ring_en),
        .status_valid(status_valid), .sleep_err(sleep_err), .clk_loss(clk_loss)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pin_pulse();
        @(negedge clk);
        rst_pin_n = 1'b0;
        @(negedge clk);
        rst_pin_n = 1'b1;
    endtask

    task automatic chk_enables(string req, logic [1:0] m);
        chk(req, {7'd0, link_en}, {7'd0, m[0] == 1'b0});
        chk(req, {7'd0, ring_en}, {7'd0, m[0] == 1'b0});
        chk(req, {7'd0, status_valid}, {7'd0, m == 2'b00});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1", {6'd0, mode_o}, 8'h01);
        rd(4'd6, d); chk("R1", d, 8'h10);
        for (int i = 7; i <= 9; i++) begin rd(4'(i), d); chk("R1", d, 8'h00); end
        chk("R1", {6'd0, sleep_err, clk_loss}, 8'h00);
        chk_enables("R3", 2'b01);

        // R2/R3/R4/R5 sweep: start mode x clock config x requested bits
        for (int s = 0; s < 2; s++) begin
            for (int p = 0; p < 8; p++) begin
                for (int t = 0; t < 4; t++) begin
                    logic pdn_t, pdl_t, cur_pdl, acc;
                    logic [1:0] em;
                    pin_pulse();
                    for (int i = 0; i < 3; i++)
                        wr(4'(7 + i), p[i] ? 8'(8'h11 * (i + 1)) : 8'h00);
                    if (s == 1) wr(4'd6, 8'h00);
                    pdn_t = t[0]; pdl_t = t[1];
                    cur_pdl = (s == 0);
                    if (!pdn_t)      acc = 1'b1;
                    else if (!pdl_t) acc = !cur_pdl && (p == 7);
                    else             acc = !p[2];
                    em = acc ? {pdn_t, pdl_t} : {1'b0, cur_pdl};
                    wr(4'd6, {3'd0, pdl_t, pdn_t, 3'd0});
                    chk(pdn_t ? (pdl_t ? "R5" : "R4") : "R2", {6'd0, mode_o}, {6'd0, em});
                    chk(pdn_t ? (pdl_t ? "R5" : "R4") : "R2", {7'd0, sleep_err}, {7'd0, !acc});
                    rd(4'd6, d); chk("R2", d, {3'd0, em[0], em[1], 3'd0});
                    chk_enables("R3", em);
                end
            end
        end

        // R6/R7/R8/R9 sleep sequence
        pin_pulse();
        wr(4'd7, 8'h12); wr(4'd8, 8'h34); wr(4'd9, 8'h56);
        wr(4'd6, 8'h00);
        mclk_ok = 1'b0;               // R8: clock drop in normal mode ignored
        @(negedge clk); @(negedge clk);
        chk("R8", {7'd0, clk_loss}, 8'h00);
        mclk_ok = 1'b1;
        wr(4'd6, 8'h08);
        chk("R4", {6'd0, mode_o}, 8'h02);
        wr(4'd6, 8'h00);
        chk("R7", {6'd0, mode_o}, 8'h02);
        wr(4'd7, 8'h00);
        rd(4'd7, d); chk("R6", d, 8'h12);
        rd(4'd8, d); chk("R6", d, 8'h34);
        chk("R8", {7'd0, clk_loss}, 8'h00);
        @(negedge clk); mclk_ok = 1'b0;
        @(negedge clk); mclk_ok = 1'b1;
        chk("R8", {7'd0, clk_loss}, 8'h01);
        repeat (3) @(negedge clk);
        chk("R9", {7'd0, clk_loss}, 8'h01);
        chk("R7", {6'd0, mode_o}, 8'h02);
        pin_pulse();
        chk("R7", {6'd0, mode_o}, 8'h01);
        chk("R1", {7'd0, clk_loss}, 8'h00);
        rd(4'd7, d); chk("R1", d, 8'h00);

        // Deep sleep: reg 9 zero, then 0x18
        wr(4'd9, 8'h00);
        wr(4'd6, 8'h18);
        chk("R5", {6'd0, mode_o}, 8'h03);
        chk_enables("R3", 2'b11);
        wr(4'd9, 8'h77);
        rd(4'd9, d); chk("R6", d, 8'h00);
        wr(4'd6, 8'h00);
        chk("R7", {6'd0, mode_o}, 8'h03);
        pin_pulse();
        chk("R7", {6'd0, mode_o}, 8'h01);

        // R9 sticky error survives accepted writes; rst clears
        wr(4'd6, 8'h08);
        chk("R4", {7'd0, sleep_err}, 8'h01);
        wr(4'd6, 8'h00);
        wr(4'd7, 8'h01);
        chk("R9", {7'd0, sleep_err}, 8'h01);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1", {7'd0, sleep_err}, 8'h00);
        chk("R1", {6'd0, mode_o}, 8'h01);

        // R10 read masking and unmapped addresses
        wr(4'd6, 8'hE7);
        rd(4'd6, d); chk("R10", d, 8'h00);
        chk("R10", {6'd0, mode_o}, 8'h00);
        wr(4'd6, 8'hF7);
        rd(4'd6, d); chk("R10", d, 8'h10);
        for (int a = 0; a < 16; a++) begin
            if (a < 6 || a > 9) begin
                wr(4'(a), 8'hA5);
                rd(4'(a), d); chk("R10", d, 8'h00);
            end
        end
        for (int i = 7; i <= 9; i++) begin rd(4'(i), d); chk("R10", d, 8'h00); end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule